// File: doc/BRIEF.md
# Transparent Bisync Control Recogniser

This block sits after a synchronous byte receiver that already has character alignment. Each received byte passes through it, and the block classifies it. It detects data-link control characters under a selectable code set, either ASCII or EBCDIC. It tracks data-link-escape (DLE) sequences, so that inside transparent text a control value counts only when a DLE escapes it. The block also decides, byte by byte, whether the byte enters the block check (CRC). It marks the two check bytes that follow a block terminator and pulses a block-end strobe on the second of them.

Every input byte gives one tagged output byte one clock later. The tags are:
- a data flag;
- a control identifier;
- a CRC-include flag;
- a discard flag, set for idle fill and escape bytes that carry no payload;
- a CRC-byte flag.

Downstream logic stores the data bytes and feeds the CRC unit from the include flag. It compares the received check from the CRC-byte flag.

Top module: `tbsc_recognizer`

## Requirements
- R1: While reset is low, and after it, all outputs are zero, and the recogniser is outside transparent text.
- R2: The control identifier uses this encoding: 0 none, 1 DLE, 2 SYN, 3 SOH, 4 STX, 5 ETX, 6 ETB, 7 EOT, 8 ENQ, 9 ITB.
  - With code_sel=0 (ASCII), the codes are DLE 0x10, SYN 0x16, SOH 0x01, STX 0x02, ETX 0x03, ETB 0x17, EOT 0x04, ENQ 0x05, ITB 0x1F.
  - With code_sel=1 (EBCDIC), the codes are DLE 0x10, SYN 0x32, SOH 0x01, STX 0x02, ETX 0x03, ETB 0x26, EOT 0x37, ENQ 0x2D, ITB 0x1F.
  - A byte that matches none of these codes has identifier 0.
- R3: Outside text:
  - A non-control byte is data with CRC-include set.
  - SYN is idle fill, with discard set and no CRC.
  - SOH, STX, EOT and ENQ raise their identifier with no data and no CRC.
  - DLE is tagged with discard set.
- R4: Outside text, DLE followed by STX enters transparent text. The STX is tagged as a control byte (identifier 4) with CRC-include clear.
- R5: Inside transparent text, a byte other than DLE is data with CRC-include set and identifier 0, even when its value equals a control code.
- R6: Inside text, DLE DLE gives one DLE data byte with CRC-include set. The first DLE is discarded and is left out of the CRC.
- R7: Inside text, in DLE SYN both bytes are discarded and both are left out of the CRC, and the block stays in text.
- R8: Inside text, DLE followed by ETX, ETB or ITB ends the text. The terminator keeps its identifier, with CRC-include set and no data. The next two bytes carry the CRC-byte flag with no CRC-include. block_end pulses with the second of them, after which the block is outside text.
- R9: Inside text, DLE ENQ aborts the block. ENQ is tagged with identifier 8 and no CRC, and the block returns to outside text.
- R10: Outside text, ETX, ETB or ITB end a non-transparent block. The byte gets CRC-include set, and the two following bytes are CRC bytes, as in R8.
- R11: An output is presented exactly one clock after each in_valid byte. Cycles without in_valid produce out_valid=0 with all tags zero, and they do not change the sequence state.
- R12: Outside text, DLE followed by a byte other than STX classifies that byte by the outside-text rules. A repeated DLE keeps the escape pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_sel | input | 1 | 0 ASCII, 1 EBCDIC control code set |
| in_valid | input | 1 | Received byte strobe |
| in_byte | input | 8 | Received byte |
| out_valid | output | 1 | Tagged byte strobe |
| out_byte | output | 8 | Byte as received |
| out_data | output | 1 | Byte is payload data |
| out_ctrl | output | 4 | Control identifier (R2 encoding) |
| out_crc_inc | output | 1 | Byte enters the block check |
| out_discard | output | 1 | Byte is fill or escape, no payload |
| out_crc_byte | output | 1 | Byte is one of the received check bytes |
| block_end | output | 1 | Pulse on the second check byte |

## Verification
The bench builds the block with its default parameters: both code tables at their standard values and a check field of two bytes. With these values the code points that differ between ASCII and EBCDIC (SYN, ETB, EOT, ENQ) can be reached. A byte such as 0x32 or 0x26 is then data under one selection and a control character under the other, and random blocks switch the code set between frames to expose a decode that ignores the selection. Random transparent text draws control values often, so escaped and unescaped forms of every code appear, together with doubled DLEs, escaped SYN fill, aborts, and gaps in in_valid inside escape sequences.

// File: rtl/tbsc_pkg.sv
package tbsc_pkg;

  localparam int BYTE_W    = 8;
  localparam int NUM_CODES = 9;
  localparam int TABLE_W   = BYTE_W * NUM_CODES;
  localparam int CTRL_W    = 4;

  // Identifier of entry i in a code table is i+1.
  typedef enum logic [CTRL_W-1:0] {
    CC_NONE = 4'd0,
    CC_DLE  = 4'd1,
    CC_SYN  = 4'd2,
    CC_SOH  = 4'd3,
    CC_STX  = 4'd4,
    CC_ETX  = 4'd5,
    CC_ETB  = 4'd6,
    CC_EOT  = 4'd7,
    CC_ENQ  = 4'd8,
    CC_ITB  = 4'd9
  } ctrl_id_e;

  typedef enum logic [2:0] {
    ST_HDR     = 3'd0,
    ST_HDR_ESC = 3'd1,
    ST_TXT     = 3'd2,
    ST_TXT_ESC = 3'd3,
    ST_CRC_HI  = 3'd4,
    ST_CRC_LO  = 3'd5
  } rx_state_e;

  typedef struct packed {
    logic     data;
    ctrl_id_e ctrl;
    logic     crc_inc;
    logic     discard;
    logic     crc_byte;
    logic     blk_end;
  } tag_t;

  // Packed tables, entry i at bits [8*i +: 8], order DLE SYN SOH STX ETX ETB EOT ENQ ITB.
  localparam logic [TABLE_W-1:0] ASCII_DEFAULT  = 72'h1F_05_04_17_03_02_01_16_10;
  localparam logic [TABLE_W-1:0] EBCDIC_DEFAULT = 72'h1F_2D_37_26_03_02_01_32_10;

  function automatic logic ends_block(input ctrl_id_e c);
    return (c == CC_ETX) || (c == CC_ETB) || (c == CC_ITB);
  endfunction

  function automatic ctrl_id_e id_of_index(input int idx);
    return ctrl_id_e'(CTRL_W'(idx + 1));
  endfunction

endpackage

// File: rtl/tbsc_table_sel.sv
module tbsc_table_sel
  import tbsc_pkg::*;
#(
  parameter logic [TABLE_W-1:0] TABLE_A = ASCII_DEFAULT,
  parameter logic [TABLE_W-1:0] TABLE_B = EBCDIC_DEFAULT
) (
  input  logic               sel,
  output logic [TABLE_W-1:0] table_o
);

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_entry
    assign table_o[BYTE_W*i +: BYTE_W] = sel ? TABLE_B[BYTE_W*i +: BYTE_W]
                                             : TABLE_A[BYTE_W*i +: BYTE_W];
  end

endmodule

// File: rtl/tbsc_code_match.sv
module tbsc_code_match
  import tbsc_pkg::*;
(
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic [TABLE_W-1:0] table_i,
  output ctrl_id_e           id_o
);

  logic [NUM_CODES-1:0] hit;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_cmp
    assign hit[i] = (byte_i == table_i[BYTE_W*i +: BYTE_W]);
  end

  // Lowest table index wins if two entries share a value.
  always_comb begin
    id_o = CC_NONE;
    for (int i = NUM_CODES - 1; i >= 0; i--) begin
      if (hit[i]) id_o = id_of_index(i);
    end
  end

  always_comb begin
    assert_single_id_R2: assert (hit != '0 || id_o == CC_NONE);
  end

endmodule

// File: rtl/tbsc_seq.sv
module tbsc_seq
  import tbsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  input  ctrl_id_e  in_ctrl,
  output tag_t      tag_o,
  output rx_state_e state_o
);

  rx_state_e state_q, state_d;

  // Outside-text classification, shared by the plain and escaped header states.
  function automatic void hdr_rules(input ctrl_id_e c, output tag_t t, output rx_state_e n);
    t = '0;
    t.ctrl = c;
    n = ST_HDR;
    case (c)
      CC_NONE: begin t.data = 1'b1; t.crc_inc = 1'b1; end
      CC_DLE:  begin t.discard = 1'b1; n = ST_HDR_ESC; end
      CC_SYN:  t.discard = 1'b1;
      CC_ETX, CC_ETB, CC_ITB: begin t.crc_inc = 1'b1; n = ST_CRC_HI; end
      default: ;
    endcase
  endfunction

  always_comb begin
    tag_o   = '0;
    state_d = state_q;
    case (state_q)
      ST_HDR: hdr_rules(in_ctrl, tag_o, state_d);
      ST_HDR_ESC: begin
        if (in_ctrl == CC_STX) begin
          tag_o.ctrl = CC_STX;
          state_d    = ST_TXT;
        end else begin
          hdr_rules(in_ctrl, tag_o, state_d);
        end
      end
      ST_TXT: begin
        if (in_ctrl == CC_DLE) begin
          tag_o.ctrl    = CC_DLE;
          tag_o.discard = 1'b1;
          state_d       = ST_TXT_ESC;
        end else begin
          tag_o.data    = 1'b1;
          tag_o.crc_inc = 1'b1;
        end
      end
      ST_TXT_ESC: begin
        state_d = ST_TXT;
        if (in_ctrl == CC_DLE) begin
          tag_o.data    = 1'b1;
          tag_o.crc_inc = 1'b1;
        end else if (in_ctrl == CC_SYN) begin
          tag_o.ctrl    = CC_SYN;
          tag_o.discard = 1'b1;
        end else if (ends_block(in_ctrl)) begin
          tag_o.ctrl    = in_ctrl;
          tag_o.crc_inc = 1'b1;
          state_d       = ST_CRC_HI;
        end else if (in_ctrl == CC_ENQ) begin
          tag_o.ctrl = CC_ENQ;
          state_d    = ST_HDR;
        end else begin
          tag_o.data    = 1'b1;
          tag_o.crc_inc = 1'b1;
        end
      end
      ST_CRC_HI: begin
        tag_o.crc_byte = 1'b1;
        state_d        = ST_CRC_LO;
      end
      ST_CRC_LO: begin
        tag_o.crc_byte = 1'b1;
        tag_o.blk_end  = 1'b1;
        state_d        = ST_HDR;
      end
      default: state_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        state_q <= ST_HDR;
    else if (in_valid) state_q <= state_d;
  end

  assign state_o = state_q;

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(state_q));

  assert_crc_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CRC_HI && in_valid) |=> state_q == ST_CRC_LO);

  assert_text_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HDR_ESC && in_valid && in_ctrl == CC_STX) |=> state_q == ST_TXT);

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TXT_ESC && in_valid && in_ctrl == CC_ENQ) |=> state_q == ST_HDR);

endmodule

// File: rtl/tbsc_recognizer.sv
module tbsc_recognizer
  import tbsc_pkg::*;
#(
  parameter logic [TABLE_W-1:0] ASCII_CODES  = ASCII_DEFAULT,
  parameter logic [TABLE_W-1:0] EBCDIC_CODES = EBCDIC_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_sel,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  output logic              out_data,
  output logic [3:0]        out_ctrl,
  output logic              out_crc_inc,
  output logic              out_discard,
  output logic              out_crc_byte,
  output logic              block_end
);

  logic [TABLE_W-1:0] code_table;
  ctrl_id_e           byte_id;
  tag_t               tag_now;
  rx_state_e          seq_state;
  tag_t               tag_q;

  tbsc_table_sel #(.TABLE_A(ASCII_CODES), .TABLE_B(EBCDIC_CODES)) u_table (
    .sel     (code_sel),
    .table_o (code_table)
  );

  tbsc_code_match u_match (
    .byte_i  (in_byte),
    .table_i (code_table),
    .id_o    (byte_id)
  );

  tbsc_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ctrl  (byte_id),
    .tag_o    (tag_now),
    .state_o  (seq_state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      tag_q     <= '0;
    end else begin
      out_valid <= in_valid;
      out_byte  <= in_valid ? in_byte : '0;
      tag_q     <= in_valid ? tag_now : '0;
    end
  end

  assign out_data     = tag_q.data;
  assign out_ctrl     = tag_q.ctrl;
  assign out_crc_inc  = tag_q.crc_inc;
  assign out_discard  = tag_q.discard;
  assign out_crc_byte = tag_q.crc_byte;
  assign block_end    = tag_q.blk_end;

  assert_blkend_crc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    block_end |-> (out_valid && out_crc_byte && !out_crc_inc));

  assert_blkend_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    block_end |=> !block_end);

  assert_discard_nocrc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_discard |-> (!out_crc_inc && !out_data));

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_data && !block_end && !out_crc_byte));

  assert_data_noctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_data |-> (out_crc_inc && (out_ctrl == 4'd0)));

  assert_state_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state inside {ST_HDR, ST_HDR_ESC, ST_TXT, ST_TXT_ESC, ST_CRC_HI, ST_CRC_LO});

endmodule

// File: tb/tbsc_recognizer_test.sv
module tbsc_recognizer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       code_sel = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic       out_valid, out_data, out_crc_inc, out_discard, out_crc_byte, block_end;
  logic [7:0] out_byte;
  logic [3:0] out_ctrl;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tbsc_recognizer uut (
    .clk(clk), .rst_n(rst_n), .code_sel(code_sel), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte), .out_data(out_data), .out_ctrl(out_ctrl),
    .out_crc_inc(out_crc_inc), .out_discard(out_discard), .out_crc_byte(out_crc_byte),
    .block_end(block_end)
  );

  // Bench view of the code sets: index 1..9 = DLE SYN SOH STX ETX ETB EOT ENQ ITB.
  function automatic logic [7:0] code_of(input bit ebc, input int id);
    case (id)
      1: return 8'h10;
      2: return ebc ? 8'h32 : 8'h16;
      3: return 8'h01;
      4: return 8'h02;
      5: return 8'h03;
      6: return ebc ? 8'h26 : 8'h17;
      7: return ebc ? 8'h37 : 8'h04;
      8: return ebc ? 8'h2D : 8'h05;
      default: return 8'h1F;
    endcase
  endfunction

  function automatic int id_of(input bit ebc, input logic [7:0] b);
    for (int k = 1; k <= 9; k++) if (code_of(ebc, k) == b) return k;
    return 0;
  endfunction

  // Model state: 0 outside, 1 outside after DLE, 2 text, 3 text after DLE, 4/5 check bytes.
  int mode = 0;
  // Expected tags {data, ctrl, crc_inc, discard, crc_byte, block_end}
  bit e_data, e_inc, e_disc, e_crcb, e_end;
  int e_ctrl;
  string e_req;

  task automatic model(input logic [7:0] b);
    int id = id_of(code_sel, b);
    bit term = (id == 5) || (id == 6) || (id == 9);
    e_data = 0; e_inc = 0; e_disc = 0; e_crcb = 0; e_end = 0; e_ctrl = 0;
    if (mode == 4) begin
      e_crcb = 1; e_req = "R8"; mode = 5;
    end else if (mode == 5) begin
      e_crcb = 1; e_end = 1; e_req = "R8"; mode = 0;
    end else if (mode == 2) begin
      if (id == 1) begin e_ctrl = 1; e_disc = 1; mode = 3; e_req = "R6"; end
      else begin e_data = 1; e_inc = 1; e_req = "R5"; end
    end else if (mode == 3) begin
      mode = 2;
      if (id == 1) begin e_data = 1; e_inc = 1; e_req = "R6"; end
      else if (id == 2) begin e_ctrl = 2; e_disc = 1; e_req = "R7"; end
      else if (term) begin e_ctrl = id; e_inc = 1; mode = 4; e_req = "R8"; end
      else if (id == 8) begin e_ctrl = 8; mode = 0; e_req = "R9"; end
      else begin e_data = 1; e_inc = 1; e_req = "R5"; end
    end else if (mode == 1 && id == 4) begin
      e_ctrl = 4; mode = 2; e_req = "R4";
    end else begin
      e_req = (mode == 1) ? "R12" : "R3";
      mode = 0;
      e_ctrl = id;
      if (id == 0) begin e_data = 1; e_inc = 1; end
      else if (id == 1) begin e_disc = 1; mode = 1; end
      else if (id == 2) e_disc = 1;
      else if (term) begin e_inc = 1; mode = 4; e_req = "R10"; end
    end
  endtask

  task automatic check(input string req, input bit ok, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one byte at the falling edge, compare one clock later.
  task automatic send(input logic [7:0] b, input string tag = "");
    string r;
    in_valid = 1'b1;
    in_byte  = b;
    model(b);
    r = (tag == "") ? e_req : tag;
    @(negedge clk);
    in_valid = 1'b0;
    check(r, out_valid && out_byte == b && out_data == e_data && out_ctrl == 4'(e_ctrl) &&
          out_crc_inc == e_inc && out_discard == e_disc && out_crc_byte == e_crcb &&
          block_end == e_end, "tags{v,byte,data,ctrl,inc,disc,crcb,end}",
          {out_valid, out_byte, out_data, out_ctrl, out_crc_inc, out_discard, out_crc_byte, block_end},
          {1'b1, b, e_data, 4'(e_ctrl), e_inc, e_disc, e_crcb, e_end});
  endtask

  task automatic gap(input int n);
    in_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check("R11", !out_valid && !out_data && !block_end && !out_crc_byte && !out_discard,
            "idle outputs", {out_valid, out_data, block_end, out_crc_byte, out_discard}, 0);
    end
  endtask

  function automatic logic [7:0] text_byte(input bit ebc);
    if ($urandom_range(0, 3) == 0) return code_of(ebc, $urandom_range(2, 9));
    return 8'($urandom);
  endfunction

  task automatic random_block();
    code_sel = 1'($urandom);
    for (int k = $urandom_range(0, 2); k > 0; k--) send(code_of(code_sel, 2));
    if ($urandom_range(0, 1) == 1) begin
      send(code_of(code_sel, 3));
      for (int k = $urandom_range(0, 3); k > 0; k--) send(8'h41 + 8'($urandom_range(0, 20)));
    end
    send(8'h10);
    if ($urandom_range(0, 3) == 0) gap(1);
    send(code_of(code_sel, 4));
    for (int k = $urandom_range(1, 12); k > 0; k--) begin
      case ($urandom_range(0, 9))
        0: begin send(8'h10); send(8'h10); end
        1: begin send(8'h10); if ($urandom_range(0, 1) == 1) gap(1); send(code_of(code_sel, 2)); end
        default: begin
          logic [7:0] t = text_byte(code_sel);
          if (t == 8'h10) send(8'h10);
          send(t);
        end
      endcase
    end
    send(8'h10);
    case ($urandom_range(0, 7))
      0: send(code_of(code_sel, 8));
      1: send(code_of(code_sel, 6));
      2: send(code_of(code_sel, 9));
      default: send(code_of(code_sel, 5));
    endcase
    if (mode == 4) begin
      send(8'($urandom));
      if ($urandom_range(0, 3) == 0) gap(2);
      send(8'($urandom));
    end
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1", {out_valid, out_data, out_ctrl, out_crc_inc, out_discard, out_crc_byte, block_end} == '0,
          "outputs in reset", {out_valid, out_data, out_ctrl, out_crc_inc, out_discard, out_crc_byte, block_end}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", !out_valid && !block_end, "outputs after reset", {out_valid, block_end}, 0);
    send(8'h02, "R1");   // outside text after reset: plain STX, no text entry
    send(8'h02, "R1");

    // R2: code-set dependent values
    code_sel = 1'b1;
    send(8'h32, "R2"); send(8'h26, "R2"); send(8'h00); send(8'h00);
    send(8'h37, "R2"); send(8'h2D, "R2"); send(8'h16, "R2"); send(8'h05, "R2");
    code_sel = 1'b0;
    send(8'h16, "R2"); send(8'h32, "R2"); send(8'h04, "R2"); send(8'h37, "R2");

    // R12: escape pending outside text
    send(8'h10); send(8'h10); send(8'h41, "R12"); send(8'h10); send(8'h01, "R12");
    // R4 entry with gap, R5 control values as data, R6, R7, R8
    send(8'h10); gap(2); send(8'h02, "R4");
    send(8'h03, "R5"); send(8'h16, "R5"); send(8'h17, "R5");
    send(8'h10); send(8'h10, "R6");
    send(8'h10); gap(1); send(8'h16, "R7"); send(8'h55, "R7");
    send(8'h10); send(8'h17, "R8"); send(8'hAA); gap(1); send(8'h55, "R8");
    send(8'h61, "R8");
    // R9 abort
    send(8'h10); send(8'h02); send(8'h44); send(8'h10); send(8'h05, "R9"); send(8'h03, "R9");
    send(8'h12); send(8'h34, "R10");
    // R10 outside terminator
    send(8'h30); send(8'h1F, "R10"); send(8'h10, "R10"); send(8'h10, "R10"); send(8'h41, "R10");

    for (int n = 0; n < 150; n++) random_block();
    for (int n = 0; n < 300; n++) begin
      code_sel = 1'($urandom);
      send(($urandom_range(0, 1) == 1) ? code_of(code_sel, $urandom_range(1, 9)) : 8'($urandom));
      if ($urandom_range(0, 7) == 0) gap(1);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule